// File: doc/BRIEF.md
# Banked SECDED Memory Guard

This block sits between a 64-bit memory request port and a word store split into several interleaved banks. Every stored word carries 64 data bits and an 8-bit check code from an extended Hamming (72,64) code. Writes generate the code on the way in. Reads check it, return single-bit errors corrected, and report multi-bit errors. Each bank keeps its own capture registers for the first single-bit error and the first multi-bit error. It also holds its own error-injection values, so software can plant a known fault and then confirm the detection path.

A 16-bit status vector holds four event classes per bank: corrected error, uncorrectable error, partial-strobe write and bad access. A status-enable mask decides which events may set their flag. A signal-enable mask decides which flags drive the interrupt. Flags clear only when a one is written to them on the clear port. A global enable switches checking on or off. Memory must be filled with full-width writes before checked reads mean anything.

Top module: `banked_ecc_guard`

## Requirements
- R1: After reset, `status`, `irq` and `resp_valid` are all zero.
- R2: A full-strobe write followed by a read of the same address returns the written word. `resp_valid` and `resp_rdata` appear two clock edges after the read request is sampled. Address bits [4:3] select the bank and the bits above them select the row, so the four banks at byte offsets 0x00, 0x08, 0x10 and 0x18 of each 32-byte group keep separate words.
- R3: With `ecc_on` high, a stored word with one flipped data bit reads back corrected. The read also sets status bit 4*bank+0.
- R4: On a corrected error the bank captures the byte address, the stored 8-bit code and the uncorrected low and high 32-bit halves. It also captures two one-hot masks that mark the failing bit: one for bits 31:0 and one for bits 63:32. Selecting `info_bank` with `info_multi`=0 shows these one edge later.
- R5: Two flipped bits set status bit 4*bank+1, and the read returns the raw stored data. The bank captures the address, the code and the raw halves, and both position masks read zero (`info_multi`=1).
- R6: A single flipped check-code bit counts as a corrected error: the data is returned unchanged, the flag is set and both position masks are zero.
- R7: A one on `stat_clr[i]` clears status bit i at the next edge, and a zero leaves it as it is.
- R8: An event whose `stat_en` bit is zero does not set its status flag.
- R9: `irq` is high exactly when some status bit and its `sig_en` bit are both set. It is registered on the same edge as the status.
- R10: A write whose `req_strb` is not all ones sets status bit 4*bank+2 and leaves the memory unchanged.
- R11: An access is bad when its word index is at or above NUM_BANKS*ROWS or its low three address bits are nonzero. A bad access sets status bit 4*bank+3, with the bank taken from address bits [4:3]. A bad read returns zero data with `resp_valid`, and a bad write does not touch the memory.
- R12: With `ecc_on` low at the read request, the raw stored data is returned and no corrected or uncorrectable flag is set.
- R13: While a bank's corrected-error flag is set, a later corrected error does not overwrite its capture. After the flag is cleared, the next one is captured.
- R14: Injection values loaded for a bank are XORed into the data and code of the next full, valid write to that bank only, and then disarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_on | input | 1 | Global check enable |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data |
| req_strb | input | 8 | Byte strobes |
| resp_valid | output | 1 | Read response valid |
| resp_rdata | output | 64 | Read data (corrected when enabled) |
| stat_en | input | 4*NUM_BANKS | Status-enable mask |
| sig_en | input | 4*NUM_BANKS | Interrupt-enable mask |
| stat_clr | input | 4*NUM_BANKS | Write-one-to-clear pulses |
| status | output | 4*NUM_BANKS | Flags, bit 4*bank+class |
| irq | output | 1 | Interrupt |
| inj_we | input | 1 | Load injection values |
| inj_bank | input | BANK_W | Bank for injection |
| inj_lo | input | 32 | XOR mask for data bits 31:0 |
| inj_hi | input | 32 | XOR mask for data bits 63:32 |
| inj_code | input | 8 | XOR mask for the check code |
| info_bank | input | BANK_W | Capture bank select |
| info_multi | input | 1 | 0 = corrected capture, 1 = uncorrectable capture |
| info_addr | output | ADDR_W | Captured address |
| info_code | output | 8 | Captured stored code |
| info_lo | output | 32 | Captured raw low half |
| info_hi | output | 32 | Captured raw high half |
| info_pos_lo | output | 32 | One-hot failing bit in low half |
| info_pos_hi | output | 32 | One-hot failing bit in high half |

## Verification
Read outcomes (response data, corrected or uncorrectable flags, read access flags and captures) land on the second edge after the request is sampled. Write outcomes (strobe and access flags, memory update) land on the first edge. Clears land one edge after `stat_clr`, and capture readout one edge after `info_bank`/`info_multi` change. Every bench task drives its inputs on a falling edge, waits the stated number of rising edges, and samples on the following falling edge, so each check reads the value the requirement fixes for that cycle.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int DW   = 64;
  localparam int CW   = 8;
  localparam int HW   = 32;
  localparam int NPOS = 72;

  typedef enum logic [1:0] {
    EV_SINGLE = 2'd0,
    EV_MULTI  = 2'd1,
    EV_STRB   = 2'd2,
    EV_ACCESS = 2'd3
  } ev_kind_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          single;
    logic          multi;
    logic [DW-1:0] flip;
  } dec_res_t;

  // Hamming parity bits: data bits occupy the non-power-of-two positions 3..71
  function automatic logic [6:0] secded_hamming(input logic [DW-1:0] d);
    logic [6:0] p;
    int idx;
    p   = '0;
    idx = 0;
    for (int pos = 1; pos < NPOS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[idx]) p = p ^ 7'(pos);
        idx++;
      end
    end
    return p;
  endfunction

  // Full code: bit 7 makes the parity over all 72 stored bits even
  function automatic logic [CW-1:0] secded_encode(input logic [DW-1:0] d);
    logic [6:0] p;
    p = secded_hamming(d);
    return {(^d) ^ (^p), p};
  endfunction

  // Data bit index for a syndrome, or -1 when the syndrome names no data bit
  function automatic int secded_index(input logic [6:0] s);
    int idx;
    int hit;
    idx = 0;
    hit = -1;
    for (int pos = 1; pos < NPOS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (7'(pos) == s) hit = idx;
        idx++;
      end
    end
    return hit;
  endfunction

endpackage

// File: rtl/secded_bank_mem.sv
module secded_bank_mem #(
  parameter int ROWS  = 64,
  parameter int WIDTH = 72,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [ROW_W-1:0] row,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [ROWS];

  // Single-port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[row] <= wdata;
    if (re) rdata <= mem[row];
  end

endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
(
  input  logic [DW+CW-1:0] word,
  output dec_res_t         res
);

  logic [6:0] syn;
  logic       par;
  logic       pow2;
  int         di;

  always_comb begin
    syn  = word[DW+6:DW] ^ secded_hamming(word[DW-1:0]);
    par  = ^word;
    di   = secded_index(syn);
    pow2 = (syn != 7'd0) && ((syn & (syn - 7'd1)) == 7'd0);
    res.data   = word[DW-1:0];
    res.flip   = '0;
    res.single = 1'b0;
    res.multi  = 1'b0;
    if (par) begin
      if (di >= 0) begin
        res.flip   = 64'd1 << di[5:0];
        res.data   = word[DW-1:0] ^ res.flip;
        res.single = 1'b1;
      end else if (syn == 7'd0 || pow2) begin
        res.single = 1'b1;
      end else begin
        res.multi = 1'b1;
      end
    end else if (syn != 7'd0) begin
      res.multi = 1'b1;
    end
  end

endmodule

// File: rtl/secded_err_capture.sv
module secded_err_capture
  import secded_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW-1:0]     code,
  input  logic [DW-1:0]     raw,
  input  logic [DW-1:0]     flip,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [CW-1:0]     cap_code,
  output logic [DW-1:0]     cap_raw,
  output logic [DW-1:0]     cap_flip
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr <= '0;
      cap_code <= '0;
      cap_raw  <= '0;
      cap_flip <= '0;
    end else if (take) begin
      cap_addr <= addr;
      cap_code <= code;
      cap_raw  <= raw;
      cap_flip <= flip;
    end
  end

endmodule

// File: rtl/banked_ecc_guard.sv
module banked_ecc_guard
  import secded_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_BANKS = 4,
  parameter int ROWS      = 64,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int SW       = 4 * NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ecc_on,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [7:0]        req_strb,
  output logic              resp_valid,
  output logic [DW-1:0]     resp_rdata,
  input  logic [SW-1:0]     stat_en,
  input  logic [SW-1:0]     sig_en,
  input  logic [SW-1:0]     stat_clr,
  output logic [SW-1:0]     status,
  output logic              irq,
  input  logic              inj_we,
  input  logic [BANK_W-1:0] inj_bank,
  input  logic [HW-1:0]     inj_lo,
  input  logic [HW-1:0]     inj_hi,
  input  logic [CW-1:0]     inj_code,
  input  logic [BANK_W-1:0] info_bank,
  input  logic              info_multi,
  output logic [ADDR_W-1:0] info_addr,
  output logic [CW-1:0]     info_code,
  output logic [HW-1:0]     info_lo,
  output logic [HW-1:0]     info_hi,
  output logic [HW-1:0]     info_pos_lo,
  output logic [HW-1:0]     info_pos_hi
);

  localparam int ROW_W  = $clog2(ROWS);
  localparam int WORDS  = NUM_BANKS * ROWS;
  localparam int WORD_W = ADDR_W - 3;
  localparam int MW     = DW + CW;

  // ---------------- request decode (stage 0) ----------------
  logic [BANK_W-1:0] bank_s;
  logic [ROW_W-1:0]  row_s;
  logic              addr_ok;
  logic              full_strb;
  logic              wr_ok;
  logic              rd_go;
  logic [CW-1:0]     gen_code;

  assign bank_s    = req_addr[3 +: BANK_W];
  assign row_s     = req_addr[3 + BANK_W +: ROW_W];
  assign addr_ok   = (32'(req_addr[ADDR_W-1:3]) < 32'(WORDS)) && (req_addr[2:0] == 3'd0);
  assign full_strb = &req_strb;
  assign wr_ok     = req_valid && req_write && addr_ok && full_strb;
  assign rd_go     = req_valid && !req_write && addr_ok;
  assign gen_code  = secded_encode(req_wdata);

  logic [MW-1:0] q [NUM_BANKS];

  // ---------------- per-bank storage and injection ----------------
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [HW-1:0] inj_lo_r;
    logic [HW-1:0] inj_hi_r;
    logic [CW-1:0] inj_c_r;
    logic          armed;
    logic          we_b;
    logic          re_b;
    logic [MW-1:0] wword;

    assign we_b  = wr_ok && (bank_s == BANK_W'(b));
    assign re_b  = rd_go && (bank_s == BANK_W'(b));
    assign wword = armed ? {gen_code ^ inj_c_r, req_wdata ^ {inj_hi_r, inj_lo_r}}
                         : {gen_code, req_wdata};

    always_ff @(posedge clk) begin
      if (rst) begin
        inj_lo_r <= '0;
        inj_hi_r <= '0;
        inj_c_r  <= '0;
        armed    <= 1'b0;
      end else if (inj_we && inj_bank == BANK_W'(b)) begin
        inj_lo_r <= inj_lo;
        inj_hi_r <= inj_hi;
        inj_c_r  <= inj_code;
        armed    <= 1'b1;
      end else if (we_b) begin
        armed <= 1'b0;
      end
    end

    secded_bank_mem #(.ROWS(ROWS), .WIDTH(MW)) u_mem (
      .clk  (clk),
      .we   (we_b),
      .re   (re_b),
      .row  (row_s),
      .wdata(wword),
      .rdata(q[b])
    );
  end

  // ---------------- stage 1: read in flight ----------------
  logic              rd1;
  logic              oob1;
  logic              ecc1;
  logic [BANK_W-1:0] bank1;
  logic [ADDR_W-1:0] addr1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd1   <= 1'b0;
      oob1  <= 1'b0;
      ecc1  <= 1'b0;
      bank1 <= '0;
      addr1 <= '0;
    end else begin
      rd1   <= rd_go;
      oob1  <= req_valid && !req_write && !addr_ok;
      ecc1  <= ecc_on;
      bank1 <= bank_s;
      addr1 <= req_addr;
    end
  end

  logic [MW-1:0] raw1;
  dec_res_t      dec;

  assign raw1 = q[bank1];

  secded_decoder u_dec (
    .word(raw1),
    .res (dec)
  );

  // ---------------- events, status, interrupt ----------------
  logic [SW-1:0] ev;
  logic [SW-1:0] status_d;

  always_comb begin
    ev = '0;
    if (req_valid && req_write) begin
      if (!addr_ok)        ev[4*bank_s + int'(EV_ACCESS)] = 1'b1;
      else if (!full_strb) ev[4*bank_s + int'(EV_STRB)]   = 1'b1;
    end
    if (oob1) ev[4*bank1 + int'(EV_ACCESS)] = 1'b1;
    if (rd1 && ecc1) begin
      if (dec.single) ev[4*bank1 + int'(EV_SINGLE)] = 1'b1;
      if (dec.multi)  ev[4*bank1 + int'(EV_MULTI)]  = 1'b1;
    end
  end

  assign status_d = (status & ~stat_clr) | (ev & stat_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      irq    <= |(status_d & sig_en);
    end
  end

  // ---------------- read response ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= rd1 || oob1;
      if (oob1)      resp_rdata <= '0;
      else if (ecc1) resp_rdata <= dec.data;
      else           resp_rdata <= raw1[DW-1:0];
    end
  end

  // ---------------- per-bank error capture ----------------
  logic [ADDR_W-1:0] s_addr [NUM_BANKS];
  logic [CW-1:0]     s_code [NUM_BANKS];
  logic [DW-1:0]     s_raw  [NUM_BANKS];
  logic [DW-1:0]     s_flip [NUM_BANKS];
  logic [ADDR_W-1:0] m_addr [NUM_BANKS];
  logic [CW-1:0]     m_code [NUM_BANKS];
  logic [DW-1:0]     m_raw  [NUM_BANKS];
  logic [DW-1:0]     m_flip [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cap
    logic hit;
    assign hit = rd1 && ecc1 && (bank1 == BANK_W'(b));

    secded_err_capture #(.ADDR_W(ADDR_W)) u_single (
      .clk     (clk),
      .rst     (rst),
      .take    (hit && dec.single && !status[4*b + int'(EV_SINGLE)]),
      .addr    (addr1),
      .code    (raw1[MW-1:DW]),
      .raw     (raw1[DW-1:0]),
      .flip    (dec.flip),
      .cap_addr(s_addr[b]),
      .cap_code(s_code[b]),
      .cap_raw (s_raw[b]),
      .cap_flip(s_flip[b])
    );

    secded_err_capture #(.ADDR_W(ADDR_W)) u_multi (
      .clk     (clk),
      .rst     (rst),
      .take    (hit && dec.multi && !status[4*b + int'(EV_MULTI)]),
      .addr    (addr1),
      .code    (raw1[MW-1:DW]),
      .raw     (raw1[DW-1:0]),
      .flip    ('0),
      .cap_addr(m_addr[b]),
      .cap_code(m_code[b]),
      .cap_raw (m_raw[b]),
      .cap_flip(m_flip[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      info_addr   <= '0;
      info_code   <= '0;
      info_lo     <= '0;
      info_hi     <= '0;
      info_pos_lo <= '0;
      info_pos_hi <= '0;
    end else if (info_multi) begin
      info_addr   <= m_addr[info_bank];
      info_code   <= m_code[info_bank];
      info_lo     <= m_raw[info_bank][HW-1:0];
      info_hi     <= m_raw[info_bank][DW-1:HW];
      info_pos_lo <= m_flip[info_bank][HW-1:0];
      info_pos_hi <= m_flip[info_bank][DW-1:HW];
    end else begin
      info_addr   <= s_addr[info_bank];
      info_code   <= s_code[info_bank];
      info_lo     <= s_raw[info_bank][HW-1:0];
      info_hi     <= s_raw[info_bank][DW-1:HW];
      info_pos_lo <= s_flip[info_bank][HW-1:0];
      info_pos_hi <= s_flip[info_bank][DW-1:HW];
    end
  end

endmodule

// File: rtl/banked_ecc_guard_chk.sv
module banked_ecc_guard_chk #(
  parameter int ADDR_W    = 16,
  parameter int NUM_BANKS = 4,
  parameter int ROWS      = 64,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int SW       = 4 * NUM_BANKS
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [7:0]        req_strb,
  input logic              resp_valid,
  input logic [SW-1:0]     stat_en,
  input logic [SW-1:0]     sig_en,
  input logic [SW-1:0]     stat_clr,
  input logic [SW-1:0]     status,
  input logic              irq
);

  logic        good_addr;
  logic [31:0] strb_idx;

  assign good_addr = (32'(req_addr[ADDR_W-1:3]) < 32'(NUM_BANKS * ROWS)) && (req_addr[2:0] == 3'd0);
  assign strb_idx  = 32'(4 * req_addr[3 +: BANK_W] + 2);

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(status) & ~status & ~$past(stat_clr)) == '0));

  // R8
  status_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((~$past(status) & status & ~$past(stat_en)) == '0));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((status & $past(sig_en)) != '0));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    ((status & $past(sig_en)) != '0) |-> irq);

  // R2
  resp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(req_valid && !req_write, 2));

  // R10
  strobe_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && good_addr && !(&req_strb) && stat_en[strb_idx])
      |=> status[$past(strb_idx)]);

endmodule

bind banked_ecc_guard banked_ecc_guard_chk #(
  .ADDR_W   (ADDR_W),
  .NUM_BANKS(NUM_BANKS),
  .ROWS     (ROWS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_strb  (req_strb),
  .resp_valid(resp_valid),
  .stat_en   (stat_en),
  .sig_en    (sig_en),
  .stat_clr  (stat_clr),
  .status    (status),
  .irq       (irq)
);

// File: tb/banked_ecc_guard_test.sv
`timescale 1ns/1ps
module banked_ecc_guard_test;

  localparam int ADDR_W = 16;
  localparam int NB     = 4;
  localparam int SW     = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ecc_on = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [63:0]       req_wdata = '0;
  logic [7:0]        req_strb = '0;
  logic              resp_valid;
  logic [63:0]       resp_rdata;
  logic [SW-1:0]     stat_en = '1;
  logic [SW-1:0]     sig_en = '0;
  logic [SW-1:0]     stat_clr = '0;
  logic [SW-1:0]     status;
  logic              irq;
  logic              inj_we = 1'b0;
  logic [1:0]        inj_bank = '0;
  logic [31:0]       inj_lo = '0;
  logic [31:0]       inj_hi = '0;
  logic [7:0]        inj_code = '0;
  logic [1:0]        info_bank = '0;
  logic              info_multi = 1'b0;
  logic [ADDR_W-1:0] info_addr;
  logic [7:0]        info_code;
  logic [31:0]       info_lo;
  logic [31:0]       info_hi;
  logic [31:0]       info_pos_lo;
  logic [31:0]       info_pos_hi;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  banked_ecc_guard #(.ADDR_W(ADDR_W), .NUM_BANKS(NB), .ROWS(64)) uut (.*);

  // Reference code: data bit n sits at the n-th position (from 3 up to 71)
  // that is not a power of two; check bit k covers positions with bit k set.
  function automatic logic [7:0] ref_code(input logic [63:0] d);
    logic [7:0] c;
    int n;
    c = '0;
    n = 0;
    for (int p = 3; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int k = 0; k < 7; k++) if (p[k]) c[k] = c[k] ^ d[n];
        n++;
      end
    end
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic [7:0] s);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_strb = s;
    tick();
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    tick();
    req_valid = 1'b0;
    tick();
    chk("R2 resp_valid", 64'(resp_valid), 64'd1);
    d = resp_rdata;
  endtask

  task automatic inject(input logic [1:0] b, input logic [31:0] lo, input logic [31:0] hi,
                        input logic [7:0] c);
    inj_we = 1'b1; inj_bank = b; inj_lo = lo; inj_hi = hi; inj_code = c;
    tick();
    inj_we = 1'b0;
  endtask

  task automatic clear(input logic [SW-1:0] m);
    stat_clr = m;
    tick();
    stat_clr = '0;
  endtask

  task automatic info(input logic [1:0] b, input logic m);
    info_bank = b; info_multi = m;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 status", 64'(status), 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 resp_valid", 64'(resp_valid), 64'd0);
  endtask

  task automatic t_clean();
    logic [63:0] got;
    wr(16'h0000, 64'h0123_4567_89AB_CDEF, 8'hFF);
    wr(16'h0008, 64'hFEDC_BA98_7654_3210, 8'hFF);
    wr(16'h0010, 64'h0000_0000_0000_0001, 8'hFF);
    wr(16'h0018, 64'h8000_0000_0000_0000, 8'hFF);
    wr(16'h0120, 64'hA5A5_5A5A_FFFF_0000, 8'hFF);
    rd(16'h0000, got); chk("R2 bank0 row0", got, 64'h0123_4567_89AB_CDEF);
    rd(16'h0008, got); chk("R2 bank1 row0", got, 64'hFEDC_BA98_7654_3210);
    rd(16'h0010, got); chk("R2 bank2 row0", got, 64'h0000_0000_0000_0001);
    rd(16'h0018, got); chk("R2 bank3 row0", got, 64'h8000_0000_0000_0000);
    rd(16'h0120, got); chk("R2 bank0 row9", got, 64'hA5A5_5A5A_FFFF_0000);
    chk("R2 no flags", 64'(status), 64'd0);
  endtask

  task automatic t_single();
    logic [63:0] got;
    logic [63:0] d1 = 64'h1111_2222_3333_4444;
    logic [63:0] d2 = 64'hCAFE_F00D_DEAD_BEEF;
    inject(2'd1, 32'h0000_0020, 32'h0, 8'h00);
    wr(16'h0028, d1, 8'hFF);
    rd(16'h0028, got);
    chk("R3 corrected", got, d1);
    chk("R3 flag bank1", 64'(status), 64'h0010);
    info(2'd1, 1'b0);
    chk("R4 addr", 64'(info_addr), 64'h0028);
    chk("R4 code", 64'(info_code), 64'(ref_code(d1)));
    chk("R4 raw lo", 64'(info_lo), 64'(d1[31:0] ^ 32'h20));
    chk("R4 raw hi", 64'(info_hi), 64'(d1[63:32]));
    chk("R4 pos lo", 64'(info_pos_lo), 64'h20);
    chk("R4 pos hi", 64'(info_pos_hi), 64'h0);
    inject(2'd1, 32'h0, 32'h0000_0100, 8'h00);
    wr(16'h0048, d2, 8'hFF);
    rd(16'h0048, got);
    chk("R3 corrected hi", got, d2);
    info(2'd1, 1'b0);
    chk("R13 capture held", 64'(info_addr), 64'h0028);
    clear(16'hFFEF);
    chk("R7 zero keeps flag", 64'(status), 64'h0010);
    clear(16'h0010);
    chk("R7 one clears flag", 64'(status), 64'h0);
    rd(16'h0048, got);
    info(2'd1, 1'b0);
    chk("R13 recapture addr", 64'(info_addr), 64'h0048);
    chk("R4 pos hi bit40", 64'(info_pos_hi), 64'h100);
    chk("R4 pos lo zero", 64'(info_pos_lo), 64'h0);
    clear(16'h0010);
  endtask

  task automatic t_check_bit();
    logic [63:0] got;
    logic [63:0] d = 64'h0F0F_0F0F_1234_5678;
    inject(2'd2, 32'h0, 32'h0, 8'h04);
    wr(16'h0030, d, 8'hFF);
    rd(16'h0030, got);
    chk("R6 data unchanged", got, d);
    chk("R6 single flag bank2", 64'(status), 64'h0100);
    info(2'd2, 1'b0);
    chk("R6 code", 64'(info_code), 64'(ref_code(d) ^ 8'h04));
    chk("R6 pos zero", 64'({info_pos_hi, info_pos_lo}), 64'h0);
    clear(16'h0100);
  endtask

  task automatic t_multi();
    logic [63:0] got;
    logic [63:0] d = 64'h7777_8888_9999_AAAA;
    inject(2'd3, 32'h0000_0003, 32'h0, 8'h00);
    wr(16'h0038, d, 8'hFF);
    rd(16'h0038, got);
    chk("R5 raw returned", got, d ^ 64'h3);
    chk("R5 multi flag bank3", 64'(status), 64'h2000);
    info(2'd3, 1'b1);
    chk("R5 addr", 64'(info_addr), 64'h0038);
    chk("R5 code", 64'(info_code), 64'(ref_code(d)));
    chk("R5 raw lo", 64'(info_lo), 64'(d[31:0] ^ 32'h3));
    chk("R5 pos zero", 64'({info_pos_hi, info_pos_lo}), 64'h0);
    clear(16'h2000);
    wr(16'h0058, d, 8'hFF);
    rd(16'h0058, got);
    chk("R14 injection consumed", got, d);
    chk("R14 no flag", 64'(status), 64'h0);
  endtask

  task automatic t_strobe();
    logic [63:0] got;
    wr(16'h0000, 64'hDEAD_DEAD_DEAD_DEAD, 8'h0F);
    chk("R10 strobe flag bank0", 64'(status), 64'h0004);
    rd(16'h0000, got);
    chk("R10 memory kept", got, 64'h0123_4567_89AB_CDEF);
    clear(16'h0004);
  endtask

  task automatic t_access();
    logic [63:0] got;
    rd(16'h0800, got);
    chk("R11 oob read data", got, 64'h0);
    chk("R11 oob read flag", 64'(status), 64'h0008);
    clear(16'h0008);
    wr(16'h0818, 64'h1, 8'hFF);
    chk("R11 oob write flag bank3", 64'(status), 64'h8000);
    clear(16'h8000);
    wr(16'h0009, 64'h5555, 8'hFF);
    chk("R11 misaligned flag bank1", 64'(status), 64'h0080);
    clear(16'h0080);
    rd(16'h0008, got);
    chk("R11 memory kept", got, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_mask();
    logic [63:0] got;
    stat_en = ~16'h0010;
    inject(2'd1, 32'h1, 32'h0, 8'h00);
    wr(16'h0068, 64'h4242_4242_4242_4242, 8'hFF);
    rd(16'h0068, got);
    chk("R8 masked flag", 64'(status), 64'h0);
    chk("R8 still corrected", got, 64'h4242_4242_4242_4242);
    stat_en = '1;
  endtask

  task automatic t_irq();
    logic [63:0] got;
    sig_en = 16'h2000;
    rd(16'h0068, got);
    chk("R9 flag set", 64'(status), 64'h0010);
    chk("R9 irq gated", 64'(irq), 64'd0);
    inject(2'd3, 32'h0, 32'h0000_0030, 8'h00);
    wr(16'h0078, 64'h0, 8'hFF);
    rd(16'h0078, got);
    chk("R9 irq raised", 64'(irq), 64'd1);
    clear(16'h2010);
    chk("R9 irq dropped", 64'(irq), 64'd0);
    sig_en = '0;
  endtask

  task automatic t_ecc_off();
    logic [63:0] got;
    logic [63:0] d = 64'h0BAD_C0DE_0000_FFFF;
    inject(2'd0, 32'h0, 32'h8000_0000, 8'h00);
    wr(16'h0100, d, 8'hFF);
    ecc_on = 1'b0;
    rd(16'h0100, got);
    chk("R12 raw data", got, d ^ 64'h8000_0000_0000_0000);
    chk("R12 no flag", 64'(status), 64'h0);
    ecc_on = 1'b1;
    rd(16'h0100, got);
    chk("R3 corrected bit63", got, d);
    chk("R3 flag bank0", 64'(status), 64'h0001);
    clear(16'h0001);
  endtask

  bit done = 1'b0;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    tick();
    t_clean();
    t_single();
    t_check_bit();
    t_multi();
    t_strobe();
    t_access();
    t_mask();
    t_irq();
    t_ecc_off();
    repeat (2) tick();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule